// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is one general-purpose I/O port of configurable width. It sits on a simple register bus with a write strobe, a read strobe, an address and a data word. It holds four registers:

- an output data latch;
- a direction mask, where 1 means output;
- a per-bit readback source select;
- a per-bit analog-mode mask.

It drives a pad value and a pad output enable for each bit. Pad input levels pass through a multi-flop synchronizer before they can be read back.

A read of the data register returns a value per bit, chosen as follows:

- An analog bit always reads zero.
- An input bit reads the synchronized pin.
- An output bit reads either the synchronized pin or its latch bit, as its readback select bit decides.

A write to the data register always lands in the latch, even for bits that are inputs. A read-modify-write of an input port therefore acts on the latch. Each instance decodes its own four addresses. When it is not read, it returns zero, so several ports can have their read data ORed onto a shared bus.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction, readback select, analog and latch registers are all zero, and so are pad_o and pad_oe_o.
- R2: pad_oe_o bit i equals direction bit i AND NOT analog bit i.
- R3: pad_o always equals the data latch, and it changes only on a write to the data address.
- R4: A write to the data address loads wdata_i into the latch at the next clock edge, whatever the direction bits hold.
- R5: For a digital bit with direction 1 and readback select 1, a data read returns the synchronized pin level.
- R6: For a digital bit with direction 1 and readback select 0, a data read returns the latch bit.
- R7: For a digital bit with direction 0, a data read returns the synchronized pin level, whatever its readback select bit holds.
- R8: A bit whose analog-mode bit is 1 reads 0 from the data address.
- R9: A pad level change appears in data readback after exactly two rising clock edges. One edge after the change, the old level is still returned.
- R10: The direction (default 0x9A), readback select (default 0xC0) and analog (default 0xC1) registers are written and read back at their own addresses. The data register's default address is 0x80.
- R11: rdata_o is 0 when rd_en_i is low or the address matches none of the four. A write to an unmatched address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | AW (8) | Bus address |
| wdata_i | input | W (8) | Bus write data |
| rdata_o | output | W (8) | Combinational read data, zero when not selected |
| pad_i | input | W (8) | Asynchronous pad input levels |
| pad_o | output | W (8) | Pad output value (data latch) |
| pad_oe_o | output | W (8) | Pad output enable per bit |

## Verification
The assertions check several rules on every cycle:

- an analog bit never has its output enable set;
- pad_o follows data writes and otherwise holds;
- an unaddressed read returns zero;
- analog bits read zero;
- input-mode readback equals the pad level from two edges earlier.

The bench scenarios cover the rest: the reset values, the per-bit choice between pin and latch for output bits, the readback of the configuration registers, the absence of side effects from unmatched writes, and the exact edge on which a pin change first appears.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DATA = 3'd1,
    SEL_DIR  = 3'd2,
    SEL_RSEL = 3'd3,
    SEL_ANA  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          AW        = 8,
  parameter logic [AW-1:0] DATA_ADDR = 8'h80,
  parameter logic [AW-1:0] DIR_ADDR  = 8'h9A,
  parameter logic [AW-1:0] RSEL_ADDR = 8'hC0,
  parameter logic [AW-1:0] ANA_ADDR  = 8'hC1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output reg_sel_e      sel_o,
  output logic [W-1:0]  latch_o,
  output logic [W-1:0]  dir_o,
  output logic [W-1:0]  rsel_o,
  output logic [W-1:0]  ana_o
);
  reg_sel_e sel;

  always_comb begin
    if      (addr_i == DATA_ADDR) sel = SEL_DATA;
    else if (addr_i == DIR_ADDR)  sel = SEL_DIR;
    else if (addr_i == RSEL_ADDR) sel = SEL_RSEL;
    else if (addr_i == ANA_ADDR)  sel = SEL_ANA;
    else                          sel = SEL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
      rsel_o  <= '0;
      ana_o   <= '0;
    end else if (wr_en_i) begin
      // latch written regardless of direction: RMW on input port hits latch
      case (sel)
        SEL_DATA: latch_o <= wdata_i;
        SEL_DIR:  dir_o   <= wdata_i;
        SEL_RSEL: rsel_o  <= wdata_i;
        SEL_ANA:  ana_o   <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign sel_o = sel;
endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rd_en_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] latch_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] rsel_i,
  input  logic [W-1:0] ana_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] data_view;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (ana_i[i])                    data_view[i] = 1'b0;
      else if (dir_i[i] && !rsel_i[i]) data_view[i] = latch_i[i];
      else                             data_view[i] = pin_i[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (sel_i)
        SEL_DATA: rdata_o = data_view;
        SEL_DIR:  rdata_o = dir_i;
        SEL_RSEL: rdata_o = rsel_i;
        SEL_ANA:  rdata_o = ana_i;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int            W           = 8,
  parameter int            AW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] DATA_ADDR   = 8'h80,
  parameter logic [AW-1:0] DIR_ADDR    = 8'h9A,
  parameter logic [AW-1:0] RSEL_ADDR   = 8'hC0,
  parameter logic [AW-1:0] ANA_ADDR    = 8'hC1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [W-1:0]  pad_i,
  output logic [W-1:0]  pad_o,
  output logic [W-1:0]  pad_oe_o
);
  reg_sel_e     sel;
  logic [W-1:0] latch_q, dir_q, rsel_q, ana_q, pin_sync;

  gpio_port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pin_sync)
  );

  gpio_port_regs #(
    .W(W), .AW(AW), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR),
    .RSEL_ADDR(RSEL_ADDR), .ANA_ADDR(ANA_ADDR)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .sel_o  (sel),
    .latch_o(latch_q),
    .dir_o  (dir_q),
    .rsel_o (rsel_q),
    .ana_o  (ana_q)
  );

  gpio_port_rdmux #(.W(W)) u_rdmux (
    .rd_en_i(rd_en_i),
    .sel_i  (sel),
    .latch_i(latch_q),
    .dir_i  (dir_q),
    .rsel_i (rsel_q),
    .ana_i  (ana_q),
    .pin_i  (pin_sync),
    .rdata_o(rdata_o)
  );

  assign pad_o    = latch_q;
  assign pad_oe_o = dir_q & ~ana_q; // analog pins never driven
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int            W         = 8,
  parameter int            AW        = 8,
  parameter logic [AW-1:0] DATA_ADDR = 8'h80
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [AW-1:0] addr_i,
  input logic [W-1:0]  wdata_i,
  input logic [W-1:0]  rdata_o,
  input logic [W-1:0]  pad_i,
  input logic [W-1:0]  pad_o,
  input logic [W-1:0]  pad_oe_o,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  ana_q
);
  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_OE_ANA_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ana_q) == '0); // R2

  AST_LATCH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == DATA_ADDR) |=> pad_o == $past(wdata_i)); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == DATA_ADDR) |=> $stable(pad_o)); // R3

  AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0); // R11

  AST_ANA_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == DATA_ADDR) |-> (rdata_o & ana_q) == '0); // R8

  AST_INPUT_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && rd_en_i && addr_i == DATA_ADDR)
      |-> ((rdata_o ^ $past(pad_i, 2)) & ~dir_q & ~ana_q) == '0); // R9
endmodule

bind gpio_port gpio_port_chk #(.W(W), .AW(AW), .DATA_ADDR(DATA_ADDR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pad_i   (pad_i),
  .pad_o   (pad_o),
  .pad_oe_o(pad_oe_o),
  .dir_q   (dir_q),
  .ana_q   (ana_q)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  localparam logic [7:0] A_DATA = 8'h80;
  localparam logic [7:0] A_DIR  = 8'h9A;
  localparam logic [7:0] A_RSEL = 8'hC0;
  localparam logic [7:0] A_ANA  = 8'hC1;
  localparam logic [7:0] A_NONE = 8'h81;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  int         n_checks = 0, n_errors = 0;

  always #2.5 clk = ~clk;

  gpio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic set_pad(input logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    bus_rd(A_DIR, r);  check("R1 dir", r, 8'h00);
    bus_rd(A_RSEL, r); check("R1 rsel", r, 8'h00);
    bus_rd(A_ANA, r);  check("R1 ana", r, 8'h00);
    check("R1 pad_o", pad_out, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
  endtask

  task automatic t_config();
    logic [7:0] r;
    bus_wr(A_DIR, 8'hF0);
    check("R2 oe=dir", pad_oe, 8'hF0);
    bus_wr(A_ANA, 8'h30);
    check("R2 oe masked by analog", pad_oe, 8'hC0);
    bus_rd(A_DIR, r);  check("R10 dir readback", r, 8'hF0);
    bus_rd(A_ANA, r);  check("R10 ana readback", r, 8'h30);
    bus_wr(A_RSEL, 8'h5A);
    bus_rd(A_RSEL, r); check("R10 rsel readback", r, 8'h5A);
    bus_wr(A_ANA, 8'h00);
    bus_wr(A_RSEL, 8'h00);
  endtask

  task automatic t_latch_input();
    bus_wr(A_DIR, 8'h00);
    bus_wr(A_DATA, 8'hA5);
    check("R4 latch written while input", pad_out, 8'hA5);
    check("R3 pad_o follows latch", pad_out, 8'hA5);
  endtask

  task automatic t_readsel();
    logic [7:0] r;
    bus_wr(A_DIR, 8'hFF);
    bus_wr(A_RSEL, 8'h0F);
    bus_wr(A_DATA, 8'h3C);
    set_pad(8'h99);
    bus_rd(A_DATA, r);
    check("R5 output+select reads pin", r & 8'h0F, 8'h09);
    check("R6 output reads latch", r & 8'hF0, 8'h30);
  endtask

  task automatic t_input();
    logic [7:0] r;
    bus_wr(A_DIR, 8'h00);
    bus_wr(A_DATA, 8'h00);
    bus_wr(A_RSEL, 8'hFF);
    set_pad(8'h5A);
    bus_rd(A_DATA, r); check("R7 input rsel=1", r, 8'h5A);
    bus_wr(A_RSEL, 8'h00);
    bus_rd(A_DATA, r); check("R7 input rsel=0", r, 8'h5A);
  endtask

  task automatic t_analog();
    logic [7:0] r;
    bus_wr(A_ANA, 8'h81);
    set_pad(8'hFF);
    bus_rd(A_DATA, r); check("R8 analog input reads 0", r, 8'h7E);
    bus_wr(A_DIR, 8'hFF);
    bus_wr(A_DATA, 8'hFF);
    bus_rd(A_DATA, r); check("R8 analog output reads 0", r, 8'h7E);
    check("R2 analog oe off", pad_oe, 8'h7E);
    bus_wr(A_ANA, 8'h00);
    bus_wr(A_DIR, 8'h00);
  endtask

  task automatic t_sync();
    logic [7:0] r;
    set_pad(8'h00);
    @(negedge clk);
    pad_in = 8'hC3;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b1; addr = A_DATA;
    #1 r = rdata;
    check("R9 old level after one edge", r, 8'h00);
    @(posedge clk);
    @(negedge clk);
    #1 r = rdata;
    rd_en = 1'b0;
    check("R9 new level after two edges", r, 8'hC3);
  endtask

  task automatic t_decode();
    logic [7:0] r;
    @(negedge clk);
    addr = A_DIR; rd_en = 1'b0;
    #1 check("R11 no strobe reads 0", rdata, 8'h00);
    bus_rd(A_NONE, r); check("R11 unmapped read 0", r, 8'h00);
    bus_wr(A_DATA, 8'h11);
    bus_wr(A_NONE, 8'hFF);
    check("R11 unmapped write latch", pad_out, 8'h11);
    bus_rd(A_DIR, r);  check("R11 unmapped write dir", r, 8'h00);
    bus_rd(A_RSEL, r); check("R11 unmapped write rsel", r, 8'h00);
    bus_rd(A_ANA, r);  check("R11 unmapped write ana", r, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_latch_input();
    t_readsel();
    t_input();
    t_analog();
    t_sync();
    t_decode();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule